// File: doc/BRIEF.md
# Call-Frame Stack Sequencer

This block keeps the stack pointer and the frame (base) pointer of a processor and carries out the entry and exit sequences of a subroutine call frame against a single-port word memory. One command is accepted at a time. Besides plain push and pop, it performs the full frame prologue: call pushes a return address, and enter saves the old frame pointer, points the frame pointer at the new frame and reserves room for locals. It also performs the full epilogue: leave cuts the stack back to the frame and restores the saved frame pointer, return pops the return address, and drop discards the caller's parameters.

The stack grows upward. A push stores at the stack pointer and then increments it. A pop decrements the stack pointer and then reads. While a subroutine runs, the frame pointer does not move, so parameters and locals can be reached at fixed offsets from it. Function results travel in a register outside this block. Popped words and return addresses appear on `ret_data` when the command's `done` pulse arrives. The memory port issues a request and address and returns read data one cycle later.

The stack may occupy addresses from `STK_BASE` up to `STK_LIMIT - 1`. Any step that would move the stack pointer out of the range from `STK_BASE` to `STK_LIMIT` is refused. The block then raises a sticky error flag.

Top module: `frame_seq`

## Requirements
- R1: After reset, `stk_ptr` and `frame_ptr` both equal `STK_BASE`, `err` is 0, `done` is 0 and `cmd_ready` is 1.
- R2: Push (`cmd_op` = 0) writes `cmd_arg` at address `stk_ptr` and then increments `stk_ptr` by one.
- R3: Call (`cmd_op` = 2) stores the return address in `cmd_arg` in the same way as push.
- R4: Pop (`cmd_op` = 1) decrements `stk_ptr` and presents the word at the new `stk_ptr` on `ret_data` when `done` pulses.
- R5: Return (`cmd_op` = 5) pops the return address in the same way as pop and presents it on `ret_data`.
- R6: Enter (`cmd_op` = 3, `cmd_arg` = locals size) stores the old `frame_ptr` (zero-extended) at `stk_ptr` and increments `stk_ptr`. It then loads `frame_ptr` from `stk_ptr`, and finally adds the locals size to `stk_ptr`.
- R7: Leave (`cmd_op` = 4) sets `stk_ptr` to `frame_ptr - 1` and reloads `frame_ptr` from the low bits of the word stored at that address.
- R8: Drop (`cmd_op` = 6, `cmd_arg` = parameter count) subtracts `cmd_arg` from `stk_ptr` without touching memory.
- R9: A command is accepted on a rising edge where both `cmd_valid` and `cmd_ready` are 1. `cmd_ready` stays 0 from then until `done` rises, and commands offered in that time are ignored. `done` is a single-cycle pulse, and `cmd_ready` is 1 in the same cycle.
- R10: A step is refused if it would take `stk_ptr` above `STK_LIMIT` or below `STK_BASE`. This covers push, call and the enter save when `stk_ptr` equals `STK_LIMIT`; pop and return when `stk_ptr` equals `STK_BASE`; an oversize drop or locals size; and leave when `frame_ptr` equals `STK_BASE`. A refused step makes no memory write and no pointer change, ends the command with `done`, and sets `err`, which then stays 1 until reset. Steps of the command that already finished are kept.
- R11: `cmd_op` = 7 is a no-operation: it completes with `done` and changes neither pointer nor memory.
- R12: `done` rises on the first rising edge after the accepting edge for push, call, drop and no-operation. It rises on the second edge for pop, return and leave, and on the third edge for enter. A command refused at an earlier step finishes on that step's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_op | input | 3 | Command code (see requirements) |
| cmd_arg | input | DW | Data, return address or size operand |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read request |
| stk_ptr | output | AW | Stack pointer |
| frame_ptr | output | AW | Frame (base) pointer |
| ret_data | output | DW | Last popped word or return address |
| done | output | 1 | Command complete pulse |
| err | output | 1 | Sticky stack range error |

## Verification
The bench nests two frames and unwinds them. A design that computed the frame pointer before saving it, or leave that read at `frame_ptr` rather than one below, would hand back a wrong return address or a wrong restored frame pointer. Commands are offered while the controller is busy during enter, and a block that accepted them would push a stray word and shift every later pointer. The range edges are hit exactly: pop on an empty stack, push with the stack full, leave with no saved frame, and a locals size that overflows after the frame pointer has already moved. An off-by-one in the compare would either corrupt the word at the limit address or leave `err` clear. The `done` timing of each command kind is measured, which catches a read captured one cycle too early.

// File: rtl/fs_pkg.sv
package fs_pkg;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_CALL  = 3'd2,
    OP_ENTER = 3'd3,
    OP_LEAVE = 3'd4,
    OP_RET   = 3'd5,
    OP_DROP  = 3'd6,
    OP_NOP   = 3'd7
  } fs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_S1   = 2'd1,
    ST_S2   = 2'd2,
    ST_S3   = 2'd3
  } fs_state_e;

  // true when lo <= v <= hi
  function automatic logic fs_in_window(input logic [63:0] v,
                                        input logic [63:0] lo,
                                        input logic [63:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/fs_adj.sv
// Pointer adjuster: ptr +/- delta, computed wide enough that an underflow
// wraps far above the limit, plus a range verdict.
module fs_adj #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int unsigned STK_BASE  = 16,
  parameter int unsigned STK_LIMIT = 240
) (
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] delta,
  input  logic          dec,
  output logic [AW-1:0] nxt,
  output logic          ok
);
  localparam int WW = ((AW > DW) ? AW : DW) + 2;

  logic [WW-1:0] wide;

  always_comb begin
    if (dec) wide = WW'(ptr) - WW'(delta);
    else     wide = WW'(ptr) + WW'(delta);
    ok  = fs_pkg::fs_in_window(64'(wide), 64'(STK_BASE), 64'(STK_LIMIT));
    nxt = wide[AW-1:0];
  end
endmodule

// File: rtl/fs_ctrl.sv
// Command sequencer: holds the pointers and steps each command.
module fs_ctrl
  import fs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int unsigned STK_BASE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_arg,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] stk_ptr,
  output logic [AW-1:0] frame_ptr,
  output logic [DW-1:0] ret_data,
  output logic          done,
  output logic          err,
  // adjuster interface
  output logic [DW-1:0] adj_delta,
  output logic          adj_dec,
  input  logic [AW-1:0] adj_nxt,
  input  logic          adj_ok,
  input  logic [AW-1:0] fp_dec,
  input  logic          fp_dec_ok,
  // named events for checking
  output logic          ev_wr,
  output logic          ev_pop,
  output logic          ev_fp_ld,
  output logic          ev_fault
);
  fs_state_e     state, state_d;
  fs_op_e        op_q;
  logic [DW-1:0] arg_q;

  logic sp_ld, sp_from_fp, fp_from_sp, fp_from_mem, dout_ld, fault, fin;

  assign cmd_ready = (state == ST_IDLE);

  always_comb begin
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = stk_ptr;
    mem_wdata   = arg_q;
    adj_delta   = DW'(1);
    adj_dec     = 1'b0;
    sp_ld       = 1'b0;
    sp_from_fp  = 1'b0;
    fp_from_sp  = 1'b0;
    fp_from_mem = 1'b0;
    dout_ld     = 1'b0;
    fault       = 1'b0;
    fin         = 1'b0;
    ev_pop      = 1'b0;
    state_d     = state;
    case (state)
      ST_IDLE: if (cmd_valid) state_d = ST_S1;
      ST_S1: begin
        case (op_q)
          OP_PUSH, OP_CALL: begin
            if (adj_ok) begin
              mem_req = 1'b1;
              mem_we  = 1'b1;
              sp_ld   = 1'b1;
            end else fault = 1'b1;
            fin = 1'b1;
          end
          OP_POP, OP_RET: begin
            adj_dec = 1'b1;
            if (adj_ok) begin
              mem_req  = 1'b1;
              mem_addr = adj_nxt;
              sp_ld    = 1'b1;
              ev_pop   = 1'b1;
              state_d  = ST_S2;
            end else begin
              fault = 1'b1;
              fin   = 1'b1;
            end
          end
          OP_ENTER: begin
            if (adj_ok) begin
              mem_req   = 1'b1;
              mem_we    = 1'b1;
              mem_wdata = DW'(frame_ptr);
              sp_ld     = 1'b1;
              state_d   = ST_S2;
            end else begin
              fault = 1'b1;
              fin   = 1'b1;
            end
          end
          OP_LEAVE: begin
            if (fp_dec_ok) begin
              mem_req    = 1'b1;
              mem_addr   = fp_dec;
              sp_ld      = 1'b1;
              sp_from_fp = 1'b1;
              state_d    = ST_S2;
            end else begin
              fault = 1'b1;
              fin   = 1'b1;
            end
          end
          OP_DROP: begin
            adj_delta = arg_q;
            adj_dec   = 1'b1;
            if (adj_ok) sp_ld = 1'b1;
            else        fault = 1'b1;
            fin = 1'b1;
          end
          default: fin = 1'b1;
        endcase
      end
      ST_S2: begin
        case (op_q)
          OP_POP, OP_RET: begin
            dout_ld = 1'b1;
            fin     = 1'b1;
          end
          OP_ENTER: begin
            fp_from_sp = 1'b1;
            state_d    = ST_S3;
          end
          OP_LEAVE: begin
            fp_from_mem = 1'b1;
            fin         = 1'b1;
          end
          default: fin = 1'b1;
        endcase
      end
      ST_S3: begin
        adj_delta = arg_q;
        if (adj_ok) sp_ld = 1'b1;
        else        fault = 1'b1;
        fin = 1'b1;
      end
      default: fin = 1'b1;
    endcase
    if (fin) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_q      <= OP_NOP;
      arg_q     <= '0;
      stk_ptr   <= AW'(STK_BASE);
      frame_ptr <= AW'(STK_BASE);
      ret_data  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      state <= state_d;
      done  <= fin;
      if (fault) err <= 1'b1;
      if (cmd_ready && cmd_valid) begin
        op_q  <= fs_op_e'(cmd_op);
        arg_q <= cmd_arg;
      end
      if (sp_ld) stk_ptr <= sp_from_fp ? fp_dec : adj_nxt;
      if (fp_from_sp)       frame_ptr <= stk_ptr;
      else if (fp_from_mem) frame_ptr <= mem_rdata[AW-1:0];
      if (dout_ld) ret_data <= mem_rdata;
    end
  end

  assign ev_wr    = mem_req && mem_we;
  assign ev_fp_ld = fp_from_sp || fp_from_mem;
  assign ev_fault = fault;
endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int unsigned STK_BASE  = 16,
  parameter int unsigned STK_LIMIT = 240
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_arg,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] stk_ptr,
  output logic [AW-1:0] frame_ptr,
  output logic [DW-1:0] ret_data,
  output logic          done,
  output logic          err
);
  logic [DW-1:0] adj_delta;
  logic          adj_dec, adj_ok, fp_dec_ok;
  logic [AW-1:0] adj_nxt, fp_dec, fp_dec_unused_guard;
  logic          ev_wr, ev_pop, ev_fp_ld, ev_fault;

  fs_adj #(.AW(AW), .DW(DW), .STK_BASE(STK_BASE), .STK_LIMIT(STK_LIMIT)) u_sp_adj (
    .ptr(stk_ptr), .delta(adj_delta), .dec(adj_dec), .nxt(adj_nxt), .ok(adj_ok)
  );

  fs_adj #(.AW(AW), .DW(DW), .STK_BASE(STK_BASE), .STK_LIMIT(STK_LIMIT)) u_fp_adj (
    .ptr(frame_ptr), .delta(DW'(1)), .dec(1'b1), .nxt(fp_dec), .ok(fp_dec_ok)
  );

  assign fp_dec_unused_guard = fp_dec;

  fs_ctrl #(.AW(AW), .DW(DW), .STK_BASE(STK_BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .stk_ptr(stk_ptr), .frame_ptr(frame_ptr), .ret_data(ret_data),
    .done(done), .err(err),
    .adj_delta(adj_delta), .adj_dec(adj_dec), .adj_nxt(adj_nxt), .adj_ok(adj_ok),
    .fp_dec(fp_dec_unused_guard), .fp_dec_ok(fp_dec_ok),
    .ev_wr(ev_wr), .ev_pop(ev_pop), .ev_fp_ld(ev_fp_ld), .ev_fault(ev_fault)
  );
endmodule

// File: rtl/fs_chk.sv
module fs_chk #(
  parameter int AW = 8,
  parameter int unsigned STK_BASE  = 16,
  parameter int unsigned STK_LIMIT = 240
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] stk_ptr,
  input logic [AW-1:0] frame_ptr,
  input logic          err,
  input logic          done,
  input logic          cmd_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          ev_wr,
  input logic          ev_pop,
  input logic          ev_fp_ld,
  input logic          ev_fault
);
  a_r2_write_bumps_sp: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> stk_ptr == AW'($past(stk_ptr) + 1'b1));

  a_r2_write_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |-> mem_addr == stk_ptr);

  a_r4_pop_drops_sp: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |=> stk_ptr == AW'($past(stk_ptr) - 1'b1));

  a_r6_fp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_fp_ld |=> $stable(frame_ptr));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  a_r10_sp_range: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(stk_ptr) >= STK_BASE) && (32'(stk_ptr) <= STK_LIMIT));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r10_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |-> !(mem_req && mem_we));

  a_r10_fault_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> err);
endmodule

bind frame_seq fs_chk #(.AW(AW), .STK_BASE(STK_BASE), .STK_LIMIT(STK_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .stk_ptr(stk_ptr), .frame_ptr(frame_ptr), .err(err),
  .done(done), .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .ev_wr(ev_wr), .ev_pop(ev_pop), .ev_fp_ld(ev_fp_ld),
  .ev_fault(ev_fault)
);

// File: tb/frame_seq_bench.sv
module frame_seq_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int BASE  = 4;
  localparam int LIMIT = 20;

  localparam logic [2:0] C_PUSH = 3'd0, C_POP = 3'd1, C_CALL = 3'd2, C_ENTER = 3'd3,
                         C_LEAVE = 3'd4, C_RET = 3'd5, C_DROP = 3'd6, C_NOP = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [DW-1:0] cmd_arg = '0;
  logic mem_req, mem_we, done, err;
  logic [AW-1:0] mem_addr, stk_ptr, frame_ptr;
  logic [DW-1:0] mem_wdata, mem_rdata, ret_data;

  always #5 clk = ~clk;

  frame_seq #(.AW(AW), .DW(DW), .STK_BASE(BASE), .STK_LIMIT(LIMIT)) u_frame_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .stk_ptr(stk_ptr), .frame_ptr(frame_ptr), .ret_data(ret_data),
    .done(done), .err(err)
  );

  // word memory, one-cycle read latency
  logic [DW-1:0] ram [256];
  initial begin
    for (int i = 0; i < 256; i++) ram[i] = '0;
    mem_rdata = '0;
  end
  always @(posedge clk) if (mem_req) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    else        mem_rdata <= ram[mem_addr];
  end

  int checks = 0, fails = 0, cyc = 0, acc_cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model
  int esp, efp, eerr;
  logic [DW-1:0] edout;
  logic [DW-1:0] emem [256];
  initial for (int i = 0; i < 256; i++) emem[i] = '0;

  typedef struct { int lat; int sp; int fp; longint dout; int err; } exp_t;
  exp_t q[$];
  string tq[$];

  task automatic model(input logic [2:0] op, input logic [DW-1:0] arg, output int lat);
    lat = 1;
    case (op)
      C_PUSH, C_CALL: if (esp < LIMIT) begin emem[esp] = arg; esp++; end else eerr = 1;
      C_POP, C_RET: if (esp > BASE) begin esp--; edout = emem[esp]; lat = 2; end else eerr = 1;
      C_ENTER: if (esp < LIMIT) begin
        emem[esp] = DW'(efp); esp++; efp = esp; lat = 3;
        if (esp + int'(arg) <= LIMIT) esp += int'(arg); else eerr = 1;
      end else eerr = 1;
      C_LEAVE: if (efp > BASE) begin esp = efp - 1; efp = int'(emem[esp][AW-1:0]); lat = 2; end
               else eerr = 1;
      C_DROP: if (esp - int'(arg) >= BASE) esp -= int'(arg); else eerr = 1;
      default: ;
    endcase
  endtask

  task automatic issue(input logic [2:0] op, input logic [DW-1:0] arg, input string tag,
                       input int hold);
    exp_t e;
    int lat;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    model(op, arg, lat);
    e.lat = lat; e.sp = esp; e.fp = efp; e.dout = edout; e.err = eerr;
    @(negedge clk);
    acc_cyc = cyc;
    q.push_back(e); tq.push_back(tag);
    for (int i = 0; i < hold; i++) begin
      cmd_op = C_PUSH; cmd_arg = 16'hDEAD;
      chk("R9", "ready while busy", cmd_ready, 0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n && done) begin
    if (q.size() == 0) chk("R9", "done with nothing pending", 1, 0);
    else begin
      exp_t e;
      string t;
      e = q.pop_front(); t = tq.pop_front();
      chk("R12", {t, " latency"}, cyc - acc_cyc, e.lat);
      chk(t, "stk_ptr", stk_ptr, e.sp);
      chk(t, "frame_ptr", frame_ptr, e.fp);
      chk(t, "ret_data", ret_data, e.dout);
      chk(t, "err", err, e.err);
      chk("R9", "ready with done", cmd_ready, 1);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    esp = BASE; efp = BASE; eerr = 0; edout = '0;
    @(negedge clk);
    chk("R1", "stk_ptr", stk_ptr, BASE);
    chk("R1", "frame_ptr", frame_ptr, BASE);
    chk("R1", "err", err, 0);
    chk("R1", "done", done, 0);
    chk("R1", "ready", cmd_ready, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk("watchdog", "run finished", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    issue(C_PUSH, 16'h1111, "R2", 0);
    issue(C_PUSH, 16'h2222, "R2", 0);
    issue(C_POP, 16'h0, "R4", 0);
    issue(C_PUSH, 16'h3333, "R2", 0);
    issue(C_CALL, 16'h0ABC, "R3", 0);
    issue(C_ENTER, 16'd3, "R6", 2);        // R9 hold-off during enter
    issue(C_PUSH, 16'h5555, "R2", 0);
    issue(C_CALL, 16'h0BCD, "R3", 0);
    issue(C_ENTER, 16'd2, "R6", 0);
    issue(C_LEAVE, 16'h0, "R7", 0);
    issue(C_RET, 16'h0, "R5", 0);
    issue(C_DROP, 16'd1, "R8", 0);
    issue(C_LEAVE, 16'h0, "R7", 0);
    issue(C_RET, 16'h0, "R5", 0);
    issue(C_DROP, 16'd2, "R8", 0);
    issue(C_NOP, 16'hFFFF, "R11", 0);
    issue(C_POP, 16'h0, "R10", 0);          // empty stack
    issue(C_DROP, 16'd5, "R10", 0);
    issue(C_LEAVE, 16'h0, "R10", 0);        // no saved frame
    do_reset();
    for (int i = 0; i < LIMIT - BASE; i++) issue(C_PUSH, DW'(16'h100 + i), "R2", 0);
    issue(C_PUSH, 16'hBEEF, "R10", 0);      // stack full
    chk("R10", "no write at limit", ram[LIMIT], 0);
    issue(C_POP, 16'h0, "R4", 0);
    do_reset();
    issue(C_ENTER, 16'd20, "R10", 0);       // locals overflow after fp moves
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule